// File: doc/BRIEF.md
# Interrupt Request Combiner

This block collects twelve interrupt request lines from neighbouring units and reduces them to a single interrupt output for the processor. Each line has its own sensing mode. In edge mode the block latches a transition in the chosen direction. In level mode it latches the line for as long as the line sits at its active level. Every latched request is held in a pending register. A line can be disabled, which keeps it off the processor output without stopping it from being recorded.

Software reaches the block through a flat register port. It has a write strobe, a two-bit register select, a write data word and a combinational read data word. The four registers are: sensing mode, polarity, disable mask and pending. Writing ones to the pending register clears those bits. The block also reports the index of the lowest-numbered request that is both pending and enabled, so a handler can start with that line without scanning the register.

Top module: `irq_combiner`

## Requirements
- R1: Register select 0 is the sensing-mode register, 1 is polarity, 2 is the disable mask and 3 is pending. All four read back through `reg_rd_data`. After reset the sensing-mode register is all zeros (level), polarity is all ones, the mask is all ones (every line disabled), pending is zero, `cpu_irq` is 0 and `irq_lowest` is 0.
- R2: A write to select 0, 1 or 2 stores `reg_wr_data` at the next rising clock edge, and the new value reads back after that edge.
- R3: With sensing-mode bit 1 (edge), polarity 1 latches the pending bit on a 0-to-1 change of the line and polarity 0 latches it on a 1-to-0 change. A change in the other direction latches nothing. A latched bit stays set after the line returns to its idle level.
- R4: With sensing-mode bit 0 (level), the pending bit is set while the line is at its active level. The active level is high for polarity 1 and low for polarity 0.
- R5: Writing to select 3 clears every pending bit whose `reg_wr_data` bit is 1. Bits written as 0 keep their value.
- R6: In level mode, a clear of a line that is still at its active level has no effect, and the bit still reads 1.
- R7: In edge mode, an active edge in the same cycle as a clear of that bit leaves the bit pending.
- R8: `cpu_irq` is 1 exactly when some pending bit has mask bit 0. A line with mask bit 1 still records into pending but does not raise `cpu_irq`.
- R9: `irq_lowest` gives the smallest index whose pending bit is 1 and mask bit is 0, and gives 0 when there is none.
- R10: A change on a line first shows in pending one rising clock edge after it is presented, and `cpu_irq` follows pending in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-stage synchronizer |
| irq_lines | input | 12 | Request lines, one bit per line. Bit order: buffer manager, timer, SPI, I2C, PHY, underrun, overrun, pulse-per-second, UART receive, UART transmit, serial link, clock status (bit 0 to bit 11) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for both read and write |
| reg_wr_data | input | 12 | Write data, one bit per line |
| reg_rd_data | output | 12 | Read data of the selected register |
| cpu_irq | output | 1 | Combined interrupt to the processor |
| irq_lowest | output | 4 | Index of the lowest pending, enabled line |

## Verification
The bench sweeps all four mode and polarity combinations over every line. In each case it checks that the right transition or level is latched and that the wrong edge is ignored. A design that swapped polarity in one mode, or that latched the opposite edge, would show a pending bit on the wrong stimulus. It tries to clear a level line that is still asserted and expects the bit to survive. It also lines an edge up in the same cycle as its clear and expects the edge to win; a design that gave the clear priority would lose that interrupt. It sweeps the lowest-index report across pairs of pending lines with and without masking, and it checks that masked lines keep recording. A priority encoder scanning from the wrong end, or a mask that gated recording instead of the output, would each give wrong values.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Register select codes; decoded by the config block and the read mux.
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_POL  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_PEND = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] mode_q,
  output logic [NUM_LINES-1:0] pol_q,
  output logic [NUM_LINES-1:0] mask_q
);

  logic [NUM_LINES-1:0] mode_d, pol_d, mask_d;
  logic                 mode_en, pol_en, mask_en;

  always_comb begin
    mode_en = 1'b0;
    pol_en  = 1'b0;
    mask_en = 1'b0;
    if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_MODE: mode_en = 1'b1;
        SEL_POL:  pol_en  = 1'b1;
        SEL_MASK: mask_en = 1'b1;
        default:  ;
      endcase
    end
    mode_d = mode_en ? wr_data : mode_q;
    pol_d  = pol_en  ? wr_data : pol_q;
    mask_d = mask_en ? wr_data : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '1;
      mask_q <= '1;
    end else begin
      mode_q <= mode_d;
      pol_q  <= pol_d;
      mask_q <= mask_d;
    end
  end

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel_e'(wr_sel) == SEL_MASK) |=> (mask_q == $past(wr_data)));

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic edge_mode,
  input  logic pol,
  input  logic clr,
  output logic pend_q
);

  logic prev_q;
  logic active, edge_hit, evt, pend_d;

  always_comb begin
    active   = pol ? line_in : ~line_in;
    edge_hit = pol ? (line_in & ~prev_q) : (~line_in & prev_q);
    evt      = edge_mode ? edge_hit : active;
    // a fresh event outranks a clear in the same cycle
    pend_d   = evt | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_in;
      pend_q <= pend_d;
    end
  end

  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && active && clr) |=> pend_q);

  // R7
  edge_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && edge_hit && clr) |=> pend_q);

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && clr && edge_mode && !edge_hit) |=> !pend_q);

  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && edge_mode && !edge_hit) |=> !pend_q);

endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int unsigned NUM_LINES = 12,
  localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] req,
  output logic [IDX_W-1:0]     idx,
  output logic                 any
);

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 12,
  localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 reg_wr_en,
  input  logic [1:0]           reg_addr,
  input  logic [NUM_LINES-1:0] reg_wr_data,
  output logic [NUM_LINES-1:0] reg_rd_data,
  output logic                 cpu_irq,
  output logic [IDX_W-1:0]     irq_lowest
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_LINES-1:0] mode_q, pol_q, mask_q, pend_vec, clr_vec, live_vec;
  logic                 enc_any;

  irq_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (reg_wr_en),
    .wr_sel  (reg_addr),
    .wr_data (reg_wr_data),
    .mode_q  (mode_q),
    .pol_q   (pol_q),
    .mask_q  (mask_q)
  );

  always_comb begin
    clr_vec = (reg_wr_en && reg_sel_e'(reg_addr) == SEL_PEND) ? reg_wr_data : '0;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .line_in   (irq_lines[g]),
      .edge_mode (mode_q[g]),
      .pol       (pol_q[g]),
      .clr       (clr_vec[g]),
      .pend_q    (pend_vec[g])
    );
  end

  always_comb begin
    live_vec = pend_vec & ~mask_q;
  end

  irq_lowest_enc #(.NUM_LINES(NUM_LINES)) u_enc (
    .req (live_vec),
    .idx (irq_lowest),
    .any (enc_any)
  );

  always_comb begin
    cpu_irq = enc_any;
    case (reg_sel_e'(reg_addr))
      SEL_MODE: reg_rd_data = mode_q;
      SEL_POL:  reg_rd_data = pol_q;
      SEL_MASK: reg_rd_data = mask_q;
      default:  reg_rd_data = pend_vec;
    endcase
  end

  // R8
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (&mask_q) |-> !cpu_irq);

  // R9
  lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cpu_irq |-> live_vec[irq_lowest]);

  // R9
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cpu_irq |-> ((pend_vec & ~mask_q & ((NUM_LINES'(1) << irq_lowest) - NUM_LINES'(1))) == '0));

  // R9
  idle_index_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !cpu_irq |-> (irq_lowest == '0));

endmodule

// File: tb/tb_irq_combiner.sv
`timescale 1ns/1ps
module tb_irq_combiner;

  localparam int N = 12;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] irq_lines;
  logic         reg_wr_en;
  logic [1:0]   reg_addr;
  logic [N-1:0] reg_wr_data;
  logic [N-1:0] reg_rd_data;
  logic         cpu_irq;
  logic [3:0]   irq_lowest;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] rv;

  always #5 clk = ~clk;

  irq_combiner dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_lines   (irq_lines),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .cpu_irq     (cpu_irq),
    .irq_lowest  (irq_lowest)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_wr_en   = 1'b1;
    reg_addr    = a;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    irq_lines = '0;
    reg_wr_en = 1'b0;
    reg_addr = 2'd0;
    reg_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, rv); check("R1 mode", rv, 0);
    rd(2'd1, rv); check("R1 pol", rv, ALL);
    rd(2'd2, rv); check("R1 mask", rv, ALL);
    rd(2'd3, rv); check("R1 pend", rv, 0);
    check("R1 irq", cpu_irq, 0);
    check("R1 lowest", irq_lowest, 0);

    // R2 config write and readback
    wr(2'd2, 12'hA5C); rd(2'd2, rv); check("R2 mask", rv, 12'hA5C);
    wr(2'd0, 12'h3C1); rd(2'd0, rv); check("R2 mode", rv, 12'h3C1);

    // sweep every mode/polarity over every line
    for (int m = 0; m < 4; m++) begin
      logic em, pm;
      logic [N-1:0] idle;
      em = m[1];
      pm = m[0];
      idle = pm ? '0 : ALL;
      wr(2'd0, em ? ALL : '0);
      wr(2'd1, pm ? ALL : '0);
      wr(2'd2, '0);
      @(negedge clk); irq_lines = idle;
      repeat (2) @(negedge clk);
      wr(2'd3, ALL);
      rd(2'd3, rv); check("R5 clear all", rv, 0);
      check("R8 no irq", cpu_irq, 0);
      for (int i = 0; i < N; i++) begin
        @(negedge clk); irq_lines[i] = pm;
        rd(2'd3, rv); check("R10 not yet", rv, 0);
        @(negedge clk);
        rd(2'd3, rv); check(em ? "R3 latch" : "R4 latch", rv, 1 << i);
        check("R8 irq", cpu_irq, 1);
        check("R9 index", irq_lowest, i);
        if (em) begin
          @(negedge clk); irq_lines[i] = ~pm;
          @(negedge clk);
          rd(2'd3, rv); check("R3 held", rv, 1 << i);
          wr(2'd3, N'(1) << i);
          rd(2'd3, rv); check("R5 clear", rv, 0);
        end else begin
          wr(2'd3, N'(1) << i);
          rd(2'd3, rv); check("R6 level kept", rv, 1 << i);
          @(negedge clk); irq_lines[i] = ~pm;
          @(negedge clk);
          wr(2'd3, N'(1) << i);
          rd(2'd3, rv); check("R5 clear", rv, 0);
        end
      end
      if (em) begin
        @(negedge clk); irq_lines = ~idle;
        @(negedge clk);
        wr(2'd3, ALL);
        @(negedge clk); irq_lines = idle;
        @(negedge clk);
        rd(2'd3, rv); check("R3 wrong edge", rv, 0);
      end
    end

    // now in edge mode, rising, lines idle low, nothing masked
    // R7 edge together with clear
    @(negedge clk);
    irq_lines[5] = 1'b1;
    reg_wr_en = 1'b1; reg_addr = 2'd3; reg_wr_data = N'(1) << 5;
    @(negedge clk);
    reg_wr_en = 1'b0;
    rd(2'd3, rv); check("R7 edge wins", rv, 1 << 5);
    irq_lines = '0;
    wr(2'd3, ALL);

    // R5 zero bits keep their value
    @(negedge clk); irq_lines = (N'(1) << 3) | (N'(1) << 7);
    @(negedge clk);
    wr(2'd3, N'(1) << 3);
    rd(2'd3, rv); check("R5 partial", rv, 1 << 7);
    irq_lines = '0;
    wr(2'd3, ALL);

    // R8 masked line still records
    wr(2'd2, N'(1) << 2);
    @(negedge clk); irq_lines[2] = 1'b1;
    @(negedge clk);
    rd(2'd3, rv); check("R8 masked records", rv, 1 << 2);
    check("R8 masked quiet", cpu_irq, 0);
    wr(2'd2, '0);
    check("R8 unmasked", cpu_irq, 1);
    irq_lines = '0;
    wr(2'd3, ALL);

    // R9 lowest index across pairs, with and without masking
    for (int k = 0; k < N - 1; k++) begin
      @(negedge clk); irq_lines = '0;
      wr(2'd2, '0);
      wr(2'd3, ALL);
      @(negedge clk); irq_lines = (N'(1) << k) | (N'(1) << (N - 1));
      @(negedge clk);
      check("R9 pair", irq_lowest, k);
      wr(2'd2, N'(1) << k);
      check("R9 masked low", irq_lowest, N - 1);
      wr(2'd2, ALL);
      check("R9 none", irq_lowest, 0);
      check("R8 none", cpu_irq, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule